// File: doc/BRIEF.md
# RF Front-End Serial Command Receiver

This block is the slave side of a two-wire RF front-end control bus: a master-driven clock line and one data line that both ends can drive. It runs on a fast system clock and passes both bus lines through a short synchroniser. It finds the start of each sequence and shifts in a 13-bit command frame, most significant bit first: a 4-bit slave ID, an 8-bit command code and an odd parity bit. Depending on the command it then takes a 9-bit data frame or answers with one. The command applies to a small register bank, and one register of that bank drives the front-end switch controls.

The receiver answers its programmable unique ID, a 4-bit group ID and the broadcast ID 0. It carries out three command types: register-0 write (`1ddddddd`), register write (`010aaaaa` plus a data frame) and register read (`011aaaaa`). Extended command codes (`00xxxxxx`) are refused. Malformed or illegal traffic sets sticky flags in a status byte at address 0x1A. A read of that byte returns the flags and then clears them.

Implemented addresses:
- 0x00: mode register, read/write.
- 0x1A: status, read only.
- 0x1B: group ID in bits 3:0, upper bits read 0.
- 0x1D: constant 0x5A.
- 0x1E: constant 0x4C.
- 0x1F: reads `{2'b00, 2'b10, unique ID}`, and only bits 3:0 are writable.

A write to 0x1A, 0x1D or 0x1E is accepted and has no effect.

Top module: `rffe_cmd_rx`

## Requirements
- R1: A sequence starts only when data rises and then falls while the clock is low. Bits are sampled on clock falling edges. A valid command frame clocked without a preceding start has no effect.
- R2: A register write (`010aaaaa`, then 8 data bits and an odd parity bit) to 0x00 sets `mode_o` to the data byte. The write commits when the data parity bit is sampled.
- R3: A register-0 write (`1ddddddd`) sets `mode_o` to `{1'b0, ddddddd}`. Reset value of `mode_o` is 0x00 and `sdata_oe` is low.
- R4: A register read (`011aaaaa`) uses the command frame's falling edge, then one turnaround cycle. The slave then drives 8 data bits MSB first and an odd parity bit, each on a clock rising edge. On the next rising edge it drives 0 for one park cycle. It releases `sdata_oe` at the following falling edge.
- R5: Writes are accepted when the slave ID equals the unique ID (reset 3), the group ID (0x1B bits 3:0, reset 0) or 0. Any other slave ID is ignored.
- R6: A write to 0x1F replaces the unique ID with data bits 3:0, and the slave then answers only the new ID. Reads of 0x1F, 0x1D and 0x1E return the values given above, and writes to 0x1D have no effect.
- R7: A command frame with wrong parity is discarded and sets status bit 6.
- R8: Two cases set status bit 5. The first is a start during a sequence in progress, which aborts it while the new sequence proceeds normally. The second is an extended command code (`00xxxxxx`), which is discarded.
- R9: A data frame with wrong parity discards the write and sets status bit 3.
- R10: A read of an unimplemented address drives nothing and sets bit 2. A write to an unimplemented address changes nothing and sets bit 1.
- R11: A read whose slave ID is 0 or the group ID (and not the unique ID) drives nothing and sets status bit 0.
- R12: Status flags are sticky and accumulate. A unique-ID read of 0x1A returns `{1'b0, b6, b5, 1'b0, b3, b2, b1, b0}` and clears all flags afterwards, and bits 7 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Bus clock from the master |
| sdata_in | input | 1 | Resolved level of the bus data line |
| sdata_out | output | 1 | Data value driven during read-back |
| sdata_oe | output | 1 | Output enable for the data line |
| mode_o | output | 8 | Mode register contents (switch control) |

## Verification
The case where two functions meet in one event is a start that arrives partway through a command frame. On the same sampled edge, the receiver must flag a length error and begin the new sequence. The bench clocks six bits of a frame, issues a fresh start and a complete register-0 write, and then accepts the result only if `mode_o` carries the new value and the status read returns exactly bit 5. A second case is a data parity error in a write: the flag and the suppression of the commit happen at the same edge. The bench judges it by `mode_o` staying unchanged while status reads 0x08.

// File: rtl/rffe_cmd_rx.sv
module rffe_cmd_rx #(
  parameter logic [3:0] UID_RST     = 4'h3,
  parameter logic [7:0] PROD_ID     = 8'h5A,
  parameter logic [7:0] MANUF_ID    = 8'h4C,
  parameter logic [1:0] MANUF_HI    = 2'b10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       sdata_in,
  output logic       sdata_out,
  output logic       sdata_oe,
  output logic [7:0] mode_o
);

  localparam int CMD_BITS = 13;
  localparam int DAT_BITS = 9;
  localparam int RD_BITS  = 9;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_RD_TA, S_RD_OUT} st_t;

  logic [SYNC_STAGES-1:0] sclk_pipe, sdat_pipe;
  logic sclk_q, sdat_q, armed;
  st_t  st;
  logic [3:0]  cnt;
  logic [11:0] sr;
  logic [4:0]  addr_q;
  logic [8:0]  rd_sr;
  logic [7:0]  err_q, err_set;
  logic [3:0]  uid_q, gid_q;
  logic [7:0]  mode_q, rd_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_pipe <= '0;
      sdat_pipe <= '0;
      sclk_q    <= 1'b0;
      sdat_q    <= 1'b0;
    end else begin
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
      sdat_pipe <= {sdat_pipe[SYNC_STAGES-2:0], sdata_in};
      sclk_q    <= sclk_pipe[SYNC_STAGES-1];
      sdat_q    <= sdat_pipe[SYNC_STAGES-1];
    end

  wire sclk_s  = sclk_pipe[SYNC_STAGES-1];
  wire bit_in  = sdat_pipe[SYNC_STAGES-1];
  wire sc_rise = sclk_s & ~sclk_q;
  wire sc_fall = ~sclk_s & sclk_q;
  wire sd_rise = bit_in & ~sdat_q & ~sclk_s;
  wire sd_fall = ~bit_in & sdat_q & ~sclk_s;
  wire ssc     = sd_fall & armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= ~sclk_s & ~ssc & (armed | sd_rise);

  wire [12:0] cmd_word   = {sr[11:0], bit_in};
  wire [3:0]  sid        = cmd_word[12:9];
  wire [7:0]  code       = cmd_word[8:1];
  wire        cmd_par_ok = ^cmd_word;
  wire        hit_uid    = (sid == uid_q) && (sid != 4'd0);
  wire        hit_gid    = (sid == gid_q);
  wire        hit_bc     = (sid == 4'd0);
  wire        hit_any    = hit_uid | hit_gid | hit_bc;
  wire        is_r0      = code[7];
  wire        is_wr      = (code[7:5] == 3'b010);
  wire        is_rd      = (code[7:5] == 3'b011);
  wire        is_ext     = (code[7:6] == 2'b00);
  wire        cmd_evt    = (st == S_CMD) && sc_fall && (cnt == 4'(CMD_BITS-1));
  wire        cmd_ok     = cmd_evt && cmd_par_ok && hit_any;

  wire [8:0]  dat_word   = {sr[7:0], bit_in};
  wire [7:0]  dat_val    = dat_word[8:1];
  wire        dat_par_ok = ^dat_word;
  wire        dat_evt    = (st == S_DATA) && sc_fall && (cnt == 4'(DAT_BITS-1));

  function automatic logic addr_valid(input logic [4:0] a);
    return (a == 5'h00) || (a == 5'h1A) || (a == 5'h1B) ||
           (a == 5'h1D) || (a == 5'h1E) || (a == 5'h1F);
  endfunction

  always_comb
    case (code[4:0])
      5'h00:   rd_val = mode_q;
      5'h1A:   rd_val = err_q;
      5'h1B:   rd_val = {4'h0, gid_q};
      5'h1D:   rd_val = PROD_ID;
      5'h1E:   rd_val = MANUF_ID;
      5'h1F:   rd_val = {2'b00, MANUF_HI, uid_q};
      default: rd_val = 8'h00;
    endcase

  wire rd_go  = cmd_ok && is_rd && hit_uid && addr_valid(code[4:0]);
  wire rd_clr = rd_go && (code[4:0] == 5'h1A);

  always_comb begin
    err_set    = 8'h00;
    err_set[6] = cmd_evt && !cmd_par_ok;
    err_set[5] = (ssc && (st != S_IDLE)) || (cmd_ok && is_ext);
    err_set[3] = dat_evt && !dat_par_ok;
    err_set[2] = cmd_ok && is_rd && hit_uid && !addr_valid(code[4:0]);
    err_set[1] = dat_evt && dat_par_ok && !addr_valid(addr_q);
    err_set[0] = cmd_ok && is_rd && !hit_uid;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      err_q <= 8'h00;
    else if (rd_clr) err_q <= 8'h00;
    else             err_q <= err_q | err_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      addr_q    <= '0;
      rd_sr     <= '0;
      uid_q     <= UID_RST;
      gid_q     <= 4'h0;
      mode_q    <= 8'h00;
      sdata_out <= 1'b0;
      sdata_oe  <= 1'b0;
    end else if (ssc) begin
      st       <= S_CMD;
      cnt      <= '0;
      sdata_oe <= 1'b0;
    end else begin
      case (st)
        S_CMD: if (sc_fall) begin
          sr  <= {sr[10:0], bit_in};
          cnt <= cnt + 4'd1;
          if (cnt == 4'(CMD_BITS-1)) begin
            st <= S_IDLE;
            if (cmd_ok && is_r0) mode_q <= {1'b0, code[6:0]};
            if (cmd_ok && is_wr) begin
              st     <= S_DATA;
              cnt    <= '0;
              addr_q <= code[4:0];
            end
            if (rd_go) begin
              st    <= S_RD_TA;
              rd_sr <= {rd_val, ~^rd_val};
            end
          end
        end
        S_DATA: if (sc_fall) begin
          sr  <= {sr[10:0], bit_in};
          cnt <= cnt + 4'd1;
          if (cnt == 4'(DAT_BITS-1)) begin
            st <= S_IDLE;
            if (dat_par_ok)
              case (addr_q)
                5'h00:   mode_q <= dat_val;
                5'h1B:   gid_q  <= dat_val[3:0];
                5'h1F:   uid_q  <= dat_val[3:0];
                default: ;
              endcase
          end
        end
        S_RD_TA: if (sc_fall) begin
          st  <= S_RD_OUT;
          cnt <= '0;
        end
        S_RD_OUT: begin
          if (sc_rise) begin
            sdata_oe <= 1'b1;
            if (cnt < 4'(RD_BITS)) begin
              sdata_out <= rd_sr[8];
              rd_sr     <= {rd_sr[7:0], 1'b0};
              cnt       <= cnt + 4'd1;
            end else begin
              sdata_out <= 1'b0;
              cnt       <= 4'(RD_BITS+1);
            end
          end
          if (sc_fall && (cnt == 4'(RD_BITS+1))) begin
            sdata_oe <= 1'b0;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  assign mode_o = mode_q;

  assert_oe_in_readout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> (st == S_RD_OUT));
  assert_release_after_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) && !$past(ssc) |-> !sdata_out);
  assert_cmd_parity_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && !cmd_par_ok) |=> (err_q[6] && (st == S_IDLE) && $stable(mode_q)));
  assert_ext_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && is_ext) |=> (err_q[5] && (st == S_IDLE)));
  assert_data_parity_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_evt && !dat_par_ok) |=> ($stable(mode_q) && $stable(uid_q) && $stable(gid_q) && err_q[3]));
  assert_group_read_nodrive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_set[0] |=> (st == S_IDLE));
  assert_status_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (err_q == 8'h00));

endmodule

// File: tb/rffe_cmd_rx_bench.sv
module rffe_cmd_rx_bench;
  localparam int H = 8;
  localparam logic [3:0] UID0 = 4'h3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, m_en = 1'b1, m_val = 1'b0;
  logic sdata_out, sdata_oe;
  logic [7:0] mode_o;
  wire sdata_line = sdata_oe ? sdata_out : (m_en ? m_val : 1'b0);

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rffe_cmd_rx u_rffe_cmd_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(sdata_line),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .mode_o(mode_o));

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ssc();
    m_en = 1'b1; m_val = 1'b0; w(H);
    m_val = 1'b1; w(H);
    m_val = 1'b0; w(H);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b1; w(2);
    m_val = b; w(H-2);
    sclk = 1'b0; w(H);
  endtask

  task automatic send_cmd(input logic [3:0] sid, input logic [7:0] code, input bit bad);
    logic [12:0] f;
    f = {sid, code, (~^{sid, code}) ^ bad};
    for (int i = 12; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic wr0(input logic [3:0] sid, input logic [6:0] d, input bit bad);
    ssc();
    send_cmd(sid, {1'b1, d}, bad);
    send_bit(1'b0);
  endtask

  task automatic wr(input logic [3:0] sid, input logic [4:0] a, input logic [7:0] d, input bit bad);
    logic [8:0] f;
    ssc();
    send_cmd(sid, {3'b010, a}, 1'b0);
    f = {d, (~^d) ^ bad};
    for (int i = 8; i >= 0; i--) send_bit(f[i]);
    send_bit(1'b0);
  endtask

  task automatic rd(input logic [3:0] sid, input logic [4:0] a,
                    output logic [8:0] got, output bit drove, output bit park_ok);
    ssc();
    send_cmd(sid, {3'b011, a}, 1'b0);
    drove = 1'b0;
    sclk = 1'b1; w(2); m_en = 1'b0; w(H-2);
    sclk = 1'b0; w(H);
    for (int i = 8; i >= 0; i--) begin
      sclk = 1'b1; w(H);
      got[i] = sdata_line;
      drove  = drove | sdata_oe;
      sclk = 1'b0; w(H);
    end
    sclk = 1'b1; w(H);
    park_ok = drove ? (sdata_oe && !sdata_line) : 1'b1;
    sclk = 1'b0; w(H);
    park_ok = park_ok && !sdata_oe;
    m_en = 1'b1; m_val = 1'b0;
  endtask

  function automatic logic [8:0] exp_rd(input logic [7:0] v);
    return {v, ~^v};
  endfunction

  task automatic rd_chk(input string req, input logic [3:0] sid, input logic [4:0] a, input logic [7:0] v);
    logic [8:0] got; bit drove, pk;
    rd(sid, a, got, drove, pk);
    chk(req, got, exp_rd(v));
    chk({req, " park"}, {drove, pk}, 2'b11);
  endtask

  task automatic rd_none(input string req, input logic [3:0] sid, input logic [4:0] a);
    logic [8:0] got; bit drove, pk;
    rd(sid, a, got, drove, pk);
    chk({req, " nodrive"}, drove, 0);
  endtask

  initial begin
    logic [7:0] d;
    w(4); rst_n = 1'b1; w(4);
    chk("R3 reset mode", mode_o, 8'h00);
    chk("R3 reset oe", sdata_oe, 0);

    for (int i = 0; i < 128; i++) begin
      wr0(UID0, 7'(i), 1'b0);
      chk("R3 reg0 write", mode_o, i);
    end

    for (int i = 0; i < 32; i++) begin
      d = 8'(i * 37 + 5);
      wr(UID0, 5'h00, d, 1'b0);
      chk("R2 write mode", mode_o, d);
      rd_chk("R4 read mode", UID0, 5'h00, d);
    end
    rd_chk("R6 read 1D", UID0, 5'h1D, 8'h5A);
    rd_chk("R6 read 1E", UID0, 5'h1E, 8'h4C);
    rd_chk("R12 clean status", UID0, 5'h1A, 8'h00);

    wr0(UID0, 7'h11, 1'b0);
    send_cmd(UID0, 8'hAA, 1'b0);
    send_bit(1'b0);
    chk("R1 no start ignored", mode_o, 8'h11);

    wr(UID0, 5'h1B, 8'hF5, 1'b0);
    rd_chk("R5 read group", UID0, 5'h1B, 8'h05);
    wr0(4'h5, 7'h22, 1'b0);
    chk("R5 group write", mode_o, 8'h22);
    wr0(4'h0, 7'h33, 1'b0);
    chk("R5 broadcast write", mode_o, 8'h33);
    wr0(4'h9, 7'h44, 1'b0);
    chk("R5 foreign id ignored", mode_o, 8'h33);

    wr(4'h0, 5'h1F, 8'hF7, 1'b0);
    rd_chk("R6 new uid read 1F", 4'h7, 5'h1F, 8'h27);
    rd_none("R6 old uid silent", UID0, 5'h00);
    wr(4'h7, 5'h1F, 8'h03, 1'b0);
    rd_chk("R6 uid restored", UID0, 5'h1F, 8'h23);
    wr(UID0, 5'h1D, 8'h00, 1'b0);
    rd_chk("R6 1D unchanged", UID0, 5'h1D, 8'h5A);
    rd_chk("R6 status after RO write", UID0, 5'h1A, 8'h00);

    wr0(UID0, 7'h55, 1'b1);
    chk("R7 bad cmd parity discarded", mode_o, 8'h33);
    rd_chk("R7 status bit6", UID0, 5'h1A, 8'h40);
    rd_chk("R12 cleared after read", UID0, 5'h1A, 8'h00);

    ssc();
    for (int i = 0; i < 6; i++) send_bit(1'(i & 1));
    wr0(UID0, 7'h66, 1'b0);
    chk("R8 restart executes", mode_o, 8'h66);
    rd_chk("R8 status bit5 abort", UID0, 5'h1A, 8'h20);
    wr0(UID0, 7'h00, 1'b0);
    ssc(); send_cmd(UID0, 8'h05, 1'b0); send_bit(1'b0);
    chk("R8 ext no effect", mode_o, 8'h00);
    rd_chk("R8 status bit5 ext", UID0, 5'h1A, 8'h20);

    wr(UID0, 5'h00, 8'hC3, 1'b1);
    chk("R9 bad data parity discarded", mode_o, 8'h00);
    rd_chk("R9 status bit3", UID0, 5'h1A, 8'h08);

    rd_none("R10 unused read", UID0, 5'h05);
    wr(UID0, 5'h07, 8'hFF, 1'b0);
    chk("R10 unused write no effect", mode_o, 8'h00);
    rd_chk("R10 sticky bits 2 and 1", UID0, 5'h1A, 8'h06);

    rd_none("R11 broadcast read", 4'h0, 5'h00);
    rd_chk("R11 status bit0 bcast", UID0, 5'h1A, 8'h01);
    rd_none("R11 group read", 4'h5, 5'h00);
    rd_chk("R11 status bit0 group", UID0, 5'h1A, 8'h01);

    wr0(UID0, 7'h01, 1'b1);
    wr(UID0, 5'h00, 8'h10, 1'b1);
    rd_none("R12 unused read", UID0, 5'h09);
    rd_none("R12 bcast read", 4'h0, 5'h1A);
    rd_chk("R12 accumulated", UID0, 5'h1A, 8'h4D);
    rd_chk("R12 cleared", UID0, 5'h1A, 8'h00);

    summary();
  end
endmodule